// File: doc/BRIEF.md
# Buffered JTAG Bit-Shift Master

This block moves serial data over the three data-bearing JTAG pins on behalf of a processor. Software places 16-bit words into an 8-entry transmit queue, then gives a bit count together with a start pulse. The engine derives a test clock from the system clock through a programmable half-period divider. It sends the queued bits out on the data-out pin and captures the bits that come back on the data-in pin. The captured bits are packed into 16-bit words and placed into an 8-entry receive queue.

Transfers may be longer than the buffering. Software keeps the transmit queue topped up and drains the receive queue while the engine runs. If the transmit queue is empty when a new word is needed, the test clock freezes low and the engine goes idle until the next start. A captured word that finds the receive queue full is discarded without any indication. A final word shorter than 16 bits is packed toward the top of the word. Reads always present a 32-bit value whose upper half is zero.

Top module: `jtag_shift_engine`

## Requirements
- R1: After reset, busy, tck and tdi are 0, rx_rd_avail is 0 and tx_wr_ready is 1.
- R2: rx_rd_data[31:16] always reads as zero.
- R3: Each transmit word is sent least-significant bit first. tdi changes only while tck is low, so it is steady for the whole time tck is high.
- R4: tdo is sampled once per tck rising edge. In a full received word, the first captured bit is at bit 0 and the last is at bit 15.
- R5: A final word holding k<16 bits carries the captured bits in [15:16-k], in order with the first of them at bit 16-k. Bits [15-k:0] read as zero.
- R6: While a transfer runs, tck has a period of 2*max(cfg_div,1) system clocks, so a cfg_div of 0 behaves as 1. tck is low whenever busy is 0.
- R7: A start pulse with a nonzero bit_count, given while idle and with transmit data present, sets busy. The engine then gives exactly bit_count tck rising edges, and busy clears after the last falling edge.
- R8: The transmit queue holds 8 words. tx_wr_ready is 0 when it is full, and a write at that time is discarded.
- R9: The receive queue holds 8 words. A word that completes while the queue is full is dropped, and the words already stored are kept unchanged.
- R10: If the transmit queue is empty when a new word is needed, including at start, shifting stops with tck low and busy clear. No further tck edges occur until a new start.
- R11: A start while busy, or a start with bit_count 0, is ignored.
- R12: A pop while rx_rd_avail is 0 changes no queue state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_div | input | 8 | Half period of tck in system clocks (0 acts as 1) |
| start | input | 1 | One-cycle pulse that begins a transfer |
| bit_count | input | 16 | Number of bits for the transfer, 1 to 65535 |
| busy | output | 1 | Transfer in progress |
| tx_wr_valid | input | 1 | Write request for the transmit queue |
| tx_wr_data | input | 16 | Word to transmit |
| tx_wr_ready | output | 1 | Transmit queue has room |
| rx_rd_pop | input | 1 | Remove the head word of the receive queue |
| rx_rd_data | output | 32 | Head receive word, upper 16 bits zero |
| rx_rd_avail | output | 1 | Receive queue is not empty |
| tck | output | 1 | Test clock |
| tdi | output | 1 | Serial data toward the target |
| tdo | input | 1 | Serial data from the target |

## Verification
The target is modelled as tdo = tdi, optionally inverted. With the straight loopback, a bit-order fault shows up as a mirrored received word. With the inverted loopback, a path that bypasses the capture register shows up as well. Bit counts that are exact multiples of 16 are mixed with counts that are not, which separates full-word packing from partial-word packing, and divider values of 0 to 3 expose off-by-one errors in the tck period. Directed cases fill the queues past their depth, starve the transmit queue mid-transfer, and issue starts and pops that must be ignored. Each case is followed by a clean transfer to show that no state was disturbed.

// File: rtl/jse_pkg.sv
package jse_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } jse_state_e;
endpackage

// File: rtl/jse_rst_sync.sv
module jse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/jse_fifo.sv
module jse_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + AW'(1);
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
  end
endmodule

// File: rtl/jse_divider.sv
module jse_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, limit;

  assign limit = (div_n == '0) ? '0 : div_n - DIV_W'(1);
  assign tick  = en && (cnt_q == limit);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/jse_shifter.sv
module jse_shifter
  import jse_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] bit_count,
  input  logic             tick,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_empty,
  output logic             tx_pop,
  input  logic             tdo,
  output logic             tck,
  output logic             tdi,
  output logic             busy,
  output logic [W-1:0]     rx_data,
  output logic             rx_push
);
  localparam int POS_W = $clog2(W);

  jse_state_e       state_q, state_d;
  logic [W-1:0]     txs_q, txs_d, rxs_q, rxs_d, rx_next;
  logic [POS_W-1:0] txpos_q, txpos_d, rxn_q, rxn_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             tck_q, tck_d, tdi_q, tdi_d;

  assign rx_next = {tdo, rxs_q[W-1:1]};

  always_comb begin
    state_d = state_q;
    txs_d   = txs_q;
    rxs_d   = rxs_q;
    txpos_d = txpos_q;
    rxn_d   = rxn_q;
    left_d  = left_q;
    tck_d   = tck_q;
    tdi_d   = tdi_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    rx_data = rx_next;
    unique case (state_q)
      ST_IDLE: begin
        if (start && (bit_count != '0) && !tx_empty) begin
          tx_pop  = 1'b1;
          txs_d   = tx_data;
          tdi_d   = tx_data[0];
          txpos_d = '0;
          rxs_d   = '0;
          rxn_d   = '0;
          left_d  = bit_count;
          state_d = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tick) begin
          tck_d   = 1'b1;
          left_d  = left_q - CNT_W'(1);
          state_d = ST_HIGH;
          if ((rxn_q == POS_W'(W-1)) || (left_q == CNT_W'(1))) begin
            rx_push = 1'b1;
            rxs_d   = '0;
            rxn_d   = '0;
          end else begin
            rxs_d   = rx_next;
            rxn_d   = rxn_q + POS_W'(1);
          end
        end
      end
      ST_HIGH: begin
        if (tick) begin
          tck_d = 1'b0;
          if (left_q == '0) begin
            state_d = ST_IDLE;
          end else if (txpos_q == POS_W'(W-1)) begin
            if (tx_empty) begin
              state_d = ST_IDLE;
            end else begin
              tx_pop  = 1'b1;
              txs_d   = tx_data;
              tdi_d   = tx_data[0];
              txpos_d = '0;
              state_d = ST_LOW;
            end
          end else begin
            txs_d   = txs_q >> 1;
            tdi_d   = txs_q[1];
            txpos_d = txpos_q + POS_W'(1);
            state_d = ST_LOW;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      txs_q   <= '0;
      rxs_q   <= '0;
      txpos_q <= '0;
      rxn_q   <= '0;
      left_q  <= '0;
      tck_q   <= 1'b0;
      tdi_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      txs_q   <= txs_d;
      rxs_q   <= rxs_d;
      txpos_q <= txpos_d;
      rxn_q   <= rxn_d;
      left_q  <= left_d;
      tck_q   <= tck_d;
      tdi_q   <= tdi_d;
    end
  end

  assign tck  = tck_q;
  assign tdi  = tdi_q;
  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
  import jse_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              start,
  input  logic [CNT_W-1:0]  bit_count,
  output logic              busy,
  input  logic              tx_wr_valid,
  input  logic [WORD_W-1:0] tx_wr_data,
  output logic              tx_wr_ready,
  input  logic              rx_rd_pop,
  output logic [REG_W-1:0]  rx_rd_data,
  output logic              rx_rd_avail,
  output logic              tck,
  output logic              tdi,
  input  logic              tdo
);
  localparam int PAD_W = REG_W - WORD_W;

  logic              rst_sync_n;
  logic              tick;
  logic              tx_full, tx_empty, tx_pop;
  logic              rx_full, rx_empty, rx_push;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;

  jse_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  jse_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (tx_wr_valid),
    .push_data (tx_wr_data),
    .pop       (tx_pop),
    .head      (tx_head),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  jse_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (rx_push),
    .push_data (rx_word),
    .pop       (rx_rd_pop),
    .head      (rx_head),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  jse_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (busy),
    .div_n (cfg_div),
    .tick  (tick)
  );

  jse_shifter #(.W(WORD_W), .CNT_W(CNT_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .bit_count (bit_count),
    .tick      (tick),
    .tx_data   (tx_head),
    .tx_empty  (tx_empty),
    .tx_pop    (tx_pop),
    .tdo       (tdo),
    .tck       (tck),
    .tdi       (tdi),
    .busy      (busy),
    .rx_data   (rx_word),
    .rx_push   (rx_push)
  );

  assign tx_wr_ready = !tx_full;
  assign rx_rd_avail = !rx_empty;
  assign rx_rd_data  = {{PAD_W{1'b0}}, rx_head};
endmodule

// File: rtl/jse_checker.sv
module jse_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic tck,
  input logic tdi
);
  // R6: the clock is parked low whenever no transfer runs
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  // R3: data toward the target never moves while tck is high
  a_r3_tdi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> $stable(tdi));

  // R7: a transfer only begins after a start request
  a_r7_busy_by_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R10: when the engine stops, for any reason, tck is low
  a_r10_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !tck);

  // R6: a rising tck edge only happens inside a running transfer
  a_r6_rise_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> (busy && $past(busy)));
endmodule

bind jtag_shift_engine jse_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .tck   (tck),
  .tdi   (tdi)
);

// File: tb/sim_jtag_shift_engine.sv
`timescale 1ns/1ps
module sim_jtag_shift_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        start = 1'b0;
  logic [15:0] bit_count = '0;
  logic        busy;
  logic        tx_wr_valid = 1'b0;
  logic [15:0] tx_wr_data = '0;
  logic        tx_wr_ready;
  logic        rx_rd_pop = 1'b0;
  logic [31:0] rx_rd_data;
  logic        rx_rd_avail;
  logic        tck, tdi, tdo;
  logic        flip = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rise_total = 0;
  int rise_time [1024];
  logic tdi_log [1024];
  logic tck_prev = 1'b0;
  logic [15:0] words [16];

  assign tdo = tdi ^ flip;

  jtag_shift_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .start(start),
    .bit_count(bit_count), .busy(busy), .tx_wr_valid(tx_wr_valid),
    .tx_wr_data(tx_wr_data), .tx_wr_ready(tx_wr_ready), .rx_rd_pop(rx_rd_pop),
    .rx_rd_data(rx_rd_data), .rx_rd_avail(rx_rd_avail), .tck(tck),
    .tdi(tdi), .tdo(tdo)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tck && !tck_prev) begin
      rise_time[rise_total % 1024] = cyc;
      tdi_log[rise_total % 1024]   = tdi;
      rise_total = rise_total + 1;
    end
    tck_prev = tck;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] w, input int k, input logic f);
    logic [15:0] v;
    v = w ^ {16{f}};
    if (k >= 16) return v;
    v = v & ((16'd1 << k) - 16'd1);
    return v << (16 - k);
  endfunction

  task automatic write_tx(input logic [15:0] w);
    @(negedge clk);
    tx_wr_valid = 1'b1;
    tx_wr_data  = w;
    @(negedge clk);
    tx_wr_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [31:0] d, output logic avail);
    @(negedge clk);
    d     = rx_rd_data;
    avail = rx_rd_avail;
    rx_rd_pop = 1'b1;
    @(negedge clk);
    rx_rd_pop = 1'b0;
  endtask

  task automatic kick(input logic [15:0] n);
    @(negedge clk);
    start = 1'b1;
    bit_count = n;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // Runs a transfer of n bits from words[] and checks edges, period and tdi order.
  task automatic xfer(input int ndiv, input int n, input int exp_rises, input string tag);
    int base, nr, bad, per, i;
    per = (ndiv == 0) ? 2 : 2 * ndiv;
    cfg_div = 8'(ndiv);
    base = rise_total;
    kick(16'(n));
    nr = rise_total - base;
    check(nr == exp_rises, {tag, " R7 rise count"}, nr, exp_rises);
    bad = 0;
    for (i = 1; i < nr; i++)
      if (rise_time[(base + i) % 1024] - rise_time[(base + i - 1) % 1024] != per) bad++;
    check(bad == 0, {tag, " R6 tck period"}, bad, 0);
    bad = 0;
    for (i = 0; i < nr; i++)
      if (tdi_log[(base + i) % 1024] !== words[i / 16][i % 16]) bad++;
    check(bad == 0, {tag, " R3 lsb-first tdi"}, bad, 0);
    check(!tck && !busy, {tag, " R6 idle tck low"}, {tck, busy}, 0);
  endtask

  task automatic drain(input int n, input int nwords, input string tag);
    logic [31:0] d;
    logic a;
    int k;
    for (int i = 0; i < nwords; i++) begin
      k = ((n - 16 * i) >= 16) ? 16 : (n - 16 * i);
      pop_rx(d, a);
      check(a && d == {16'h0, exp_word(words[i], k, flip)},
            (k < 16) ? {tag, " R5 partial word"} : {tag, " R4 rx word"}, d,
            {16'h0, exp_word(words[i], k, flip)});
    end
  endtask

  initial begin
    logic [31:0] d;
    logic a;
    int n, nw, nd, base;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 and R2: reset state
    check(!busy && !tck && !tdi, "R1 reset outputs", {busy, tck, tdi}, 0);
    check(!rx_rd_avail && tx_wr_ready, "R1 reset queues", {rx_rd_avail, tx_wr_ready}, 2'b01);
    check(rx_rd_data[31:16] == 16'h0, "R2 upper half zero", rx_rd_data[31:16], 0);

    // Two full words at the fastest clock, straight loopback
    words[0] = 16'h8001; words[1] = 16'h3C5A;
    flip = 1'b0;
    write_tx(words[0]); write_tx(words[1]);
    xfer(1, 32, 32, "full");
    drain(32, 2, "full");

    // Partial word of 6 bits, inverted loopback, divider 3
    words[0] = 16'hA5C3;
    flip = 1'b1;
    write_tx(words[0]);
    xfer(3, 6, 6, "part");
    drain(6, 1, "part");

    // Divider value 0 behaves as 1
    words[0] = 16'h0F0F;
    write_tx(words[0]);
    xfer(0, 16, 16, "div0");
    drain(16, 1, "div0");

    // R8: ninth write into a full transmit queue is dropped
    flip = 1'b0;
    for (int i = 0; i < 8; i++) begin words[i] = 16'(16'h1111 * (i + 1)); write_tx(words[i]); end
    @(negedge clk);
    check(!tx_wr_ready, "R8 ready low when full", tx_wr_ready, 0);
    write_tx(16'hDEAD);
    xfer(1, 128, 128, "full8");
    drain(128, 8, "full8");
    @(negedge clk);
    check(!rx_rd_avail, "R8 ninth word discarded", rx_rd_avail, 0);

    // R9: overrun drops new words and keeps stored ones
    for (int i = 0; i < 5; i++) begin words[i] = 16'($urandom); write_tx(words[i]); end
    xfer(2, 80, 80, "ovr1");
    for (int i = 0; i < 5; i++) begin words[5 + i] = 16'($urandom); write_tx(words[5 + i]); end
    cfg_div = 8'd1;
    kick(16'd80);
    for (int i = 0; i < 8; i++) begin
      pop_rx(d, a);
      check(a && d[15:0] == words[i], "R9 stored words kept", d, words[i]);
    end
    @(negedge clk);
    check(!rx_rd_avail, "R9 excess words dropped", rx_rd_avail, 0);

    // R10: underrun after two words
    words[0] = 16'h1234; words[1] = 16'hFEDC;
    write_tx(words[0]); write_tx(words[1]);
    xfer(1, 48, 32, "undr");
    base = rise_total;
    repeat (40) @(negedge clk);
    check(rise_total == base && !tck, "R10 tck frozen after underrun", rise_total - base, 0);
    drain(32, 2, "undr");
    // R10: start with empty transmit queue does nothing
    base = rise_total;
    kick(16'd16);
    repeat (10) @(negedge clk);
    check(!busy && rise_total == base, "R10 start on empty queue", rise_total - base, 0);

    // R11: zero count ignored, start while busy ignored
    words[0] = 16'h5A5A; words[1] = 16'hC3C3;
    write_tx(words[0]); write_tx(words[1]);
    base = rise_total;
    kick(16'd0);
    repeat (5) @(negedge clk);
    check(!busy && rise_total == base, "R11 zero count ignored", rise_total - base, 0);
    cfg_div = 8'd2;
    base = rise_total;
    @(negedge clk); start = 1'b1; bit_count = 16'd32;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; bit_count = 16'd3;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    check(rise_total - base == 32, "R11 start while busy ignored", rise_total - base, 32);
    drain(32, 2, "r11");

    // R12: pop on empty receive queue, then a clean transfer
    pop_rx(d, a);
    @(negedge clk);
    check(!rx_rd_avail && tx_wr_ready, "R12 empty pop no change", {rx_rd_avail, tx_wr_ready}, 2'b01);
    words[0] = 16'h0BAD;
    write_tx(words[0]);
    xfer(1, 11, 11, "r12");
    drain(11, 1, "r12");
    @(negedge clk);
    check(!rx_rd_avail, "R12 queue count intact", rx_rd_avail, 0);

    // Random transfers
    for (int t = 0; t < 20; t++) begin
      n  = 1 + int'($urandom % 128);
      nw = (n + 15) / 16;
      nd = int'($urandom % 4);
      flip = 1'($urandom);
      for (int i = 0; i < nw; i++) begin words[i] = 16'($urandom); write_tx(words[i]); end
      xfer(nd, n, n, "rand");
      drain(n, nw, "rand");
      check(rx_rd_data[31:16] == 16'h0, "R2 rand upper half", rx_rd_data[31:16], 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule